// File: doc/BRIEF.md
# Dual Read/Write Bank Mapper

This block turns a CPU access inside a 64 KB host window into a video-memory address. Each access uses a bank number chosen by its direction. Reads take the read bank. Writes take the write bank. A copy from one bank to another therefore needs no register change between the load and the store.

Each 6-bit bank number is split across two 8-bit registers. The segment register holds the low four bits of both banks. The extension register holds the top two bits of both banks.

A linear-mode input bypasses banking. In linear mode the whole 22-bit CPU offset goes straight to the memory address. The access path has one register stage. An access presented in one cycle appears on the memory side in the next cycle.

Top module: `bank_mapper`

## Requirements
- R1: After reset, both bank registers read back as zero. `mem_req` is low in the first cycle after reset.
- R2: Register select 0 addresses the segment register, and it reads back all 8 written bits. Bits [3:0] are the low four write-bank bits. Bits [7:4] are the low four read-bank bits.
- R3: Register select 1 addresses the extension register. Bits [1:0] are write-bank bits [5:4], and bits [5:4] are read-bank bits [5:4]. Bits 2, 3, 6 and 7 always read back as zero, whatever was written.
- R4: A banked write access (`cpu_we`=1) produces `mem_addr` = {write bank[5:0], `cpu_ofs`[15:0]}.
- R5: A banked read access (`cpu_we`=0) produces `mem_addr` = {read bank[5:0], `cpu_ofs`[15:0]}. The read bank is independent of the write bank.
- R6: When `lin_en` is 1, `mem_addr` equals `cpu_ofs`[21:0], and both bank registers have no effect on it.
- R7: `mem_req`, `mem_we` and `mem_addr` follow `cpu_req`, `cpu_we` and the computed address one clock later. `mem_req` is low in the cycle after an idle cycle.
- R8: An access issued in the same cycle as a bank-register write uses the old bank value. The next access after that uses the new value.
- R9: In banked mode, `cpu_ofs`[21:16] has no effect on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Bank register write strobe |
| reg_sel | input | 1 | 0 selects the segment register, 1 selects the extension register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Readback of the selected register |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 for a write access, 0 for a read access |
| cpu_ofs | input | 22 | Access offset; only bits [15:0] are used in banked mode |
| lin_en | input | 1 | Linear addressing enable |
| mem_req | output | 1 | Memory request, one cycle after `cpu_req` |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | 22 | Video-memory address |

## Verification
The bench builds the block with its default parameters: a 16-bit window offset, a 4-bit low bank field and a 2-bit high bank field. At that size all 64 banks on both the read and write sides can be reached. Random register values and random offsets cover bank pairs where the read and write numbers differ in every bit position. The upper offset bits are randomised in banked mode so that any leak of them into the address is caught. Directed cases cover linear mode, the masked extension bits, and a register write that coincides with an access.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int OFS_W = 16,
  parameter int LO_W  = 4,
  parameter int HI_W  = 2,
  parameter int LIN_W = OFS_W + LO_W + HI_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [2*LO_W-1:0]  reg_wdata,
  output logic [2*LO_W-1:0]  reg_rdata,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [LIN_W-1:0]   cpu_ofs,
  input  logic               lin_en,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LIN_W-1:0]   mem_addr
);
  localparam int BANK_W = LO_W + HI_W;
  localparam int REG_W  = 2 * LO_W;

  function automatic logic [REG_W-1:0] ext_mask();
    logic [REG_W-1:0] m = '0;
    for (int i = 0; i < HI_W; i++) begin
      m[i]        = 1'b1;
      m[LO_W + i] = 1'b1;
    end
    return m;
  endfunction
  localparam logic [REG_W-1:0] EXT_MASK = ext_mask();

  logic [REG_W-1:0]  seg_q, ext_q;
  logic [BANK_W-1:0] wbank, rbank, bank;

  assign wbank = {ext_q[HI_W-1:0], seg_q[LO_W-1:0]};
  assign rbank = {ext_q[LO_W+HI_W-1:LO_W], seg_q[REG_W-1:LO_W]};
  assign bank  = cpu_we ? wbank : rbank;
  assign reg_rdata = reg_sel ? ext_q : seg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= '0;
      ext_q <= '0;
    end else if (reg_wr) begin
      if (reg_sel) ext_q <= reg_wdata & EXT_MASK;
      else         seg_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_req <= cpu_req;
      if (cpu_req) begin
        mem_we   <= cpu_we;
        mem_addr <= lin_en ? cpu_ofs : {bank, cpu_ofs[OFS_W-1:0]};
      end
    end
  end

  p_req_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |=> (mem_req && mem_we == $past(cpu_we)));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |=> !mem_req);
  p_lin_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && lin_en) |=> mem_addr == $past(cpu_ofs));
  p_low_ofs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !lin_en) |=> mem_addr[OFS_W-1:0] == $past(cpu_ofs[OFS_W-1:0]));
  p_read_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !lin_en && !cpu_we) |=> mem_addr[LIN_W-1:OFS_W] == $past(rbank));
  p_ext_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata & ~EXT_MASK) == '0);
endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0, cpu_req = 0, cpu_we = 0, lin_en = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [21:0] cpu_ofs = 0, mem_addr;
  logic mem_req, mem_we;
  int checks = 0, errors = 0;
  logic [7:0] m_seg = 0, m_ext = 0;

  always #5 clk = ~clk;

  bank_mapper uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_ofs(cpu_ofs), .lin_en(lin_en), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr));

  function automatic logic [21:0] exp_addr(logic we, logic [21:0] ofs, logic lin,
                                           logic [7:0] s, logic [7:0] e);
    if (lin) return ofs;
    return we ? {e[1:0], s[3:0], ofs[15:0]} : {e[5:4], s[7:4], ofs[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic sel, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (sel) m_ext = d & 8'h33; else m_seg = d;
  endtask

  task automatic rd_reg(string req, logic sel);
    reg_sel = sel; #1;
    chk(req, {24'd0, reg_rdata}, {24'd0, sel ? m_ext : m_seg});
  endtask

  task automatic access(string req, logic we, logic [21:0] ofs, logic lin);
    @(negedge clk); cpu_req = 1; cpu_we = we; cpu_ofs = ofs; lin_en = lin;
    @(negedge clk); cpu_req = 0;
    chk(req, {31'd0, mem_req}, 32'd1);
    chk(req, {31'd0, mem_we}, {31'd0, we});
    chk(req, {10'd0, mem_addr}, {10'd0, exp_addr(we, ofs, lin, m_seg, m_ext)});
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {31'd0, mem_req}, 32'd0);
    rd_reg("R1", 0);
    rd_reg("R1", 1);
    // R2 / R3 readback and masking
    wr_reg(0, 8'hA5); rd_reg("R2", 0);
    wr_reg(1, 8'hFF); rd_reg("R3", 1);
    chk("R3", {24'd0, reg_rdata}, 32'h33);
    // R4 / R5 directed: read and write banks differ
    wr_reg(0, 8'h3C); wr_reg(1, 8'h12);
    access("R4", 1, 22'h00_BEEF, 0);
    access("R5", 0, 22'h00_1234, 0);
    // R9 upper offset bits ignored in banked mode
    access("R9", 1, 22'h3F_0001, 0);
    access("R9", 0, 22'h2A_FFFF, 0);
    // R6 linear mode passes offset
    access("R6", 1, 22'h3A_5A5A, 1);
    access("R6", 0, 22'h15_0F0F, 1);
    // R7 idle cycle
    @(negedge clk);
    chk("R7", {31'd0, mem_req}, 32'd0);
    // R8 register write coinciding with an access
    @(negedge clk);
    reg_wr = 1; reg_sel = 0; reg_wdata = 8'hF0;
    cpu_req = 1; cpu_we = 0; cpu_ofs = 22'h00_0042; lin_en = 0;
    @(negedge clk);
    reg_wr = 0; cpu_req = 0;
    chk("R8", {10'd0, mem_addr}, {10'd0, exp_addr(0, 22'h42, 0, m_seg, m_ext)});
    m_seg = 8'hF0;
    access("R8", 0, 22'h00_0042, 0);
    // random mix
    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 5);
      if (k == 0) wr_reg(0, 8'($urandom));
      else if (k == 1) wr_reg(1, 8'($urandom));
      else if (k == 2) rd_reg("R3", 1'($urandom));
      else access($urandom_range(0, 1) ? "R4" : "R5", 1'($urandom),
                  22'($urandom), ($urandom_range(0, 7) == 0));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule